// File: doc/BRIEF.md
# Field Parity Detector

This block decides whether the next field of an interlaced video stream is the first or the second field of its frame. In its derived mode it counts pixel clocks from the moment vertical sync becomes active until horizontal sync next goes low. It compares that distance against a programmable threshold. A short distance, at or below the threshold, marks a first field. A longer distance marks a second field.

A mode input can instead take the parity straight from an external field-sync pin, sampled when vertical sync starts. The decision matters only when the video port runs as a timing slave. When the port is the timing master, the detector keeps its flag frozen and raises no strobe. Each decision is presented as a held field flag together with a one-cycle update strobe.

Top module: `field_parity_detect`

## Requirements
- R1: After reset, `field_o` is 0, which means first field, and `upd_o` is 0.
- R2: In derived mode (`use_ext_i`=0) with `slave_i`=1, let N be the number of clock edges from the cycle `vsync_i` is first seen active to the cycle `hsync_i` is first seen low. If N is less than or equal to the latched threshold, one strobe is issued and `field_o` becomes 0. The strobe appears on `upd_o` N+2 edges after `vsync_i` changes.
- R3: In the same setting, if N is greater than the latched threshold, one strobe is issued and `field_o` becomes 1, which means second field.
- R4: The threshold register is 12 bits wide and resets to 128. Right after reset, N=128 yields field 0 and N=129 yields field 1.
- R5: With `use_ext_i`=1 and `slave_i`=1, every start of vertical sync issues one strobe, and `field_o` takes the level `fsync_i` had at that start. A later falling edge of `hsync_i` does not cause a further strobe.
- R6: While `slave_i`=0, no strobe is issued and `field_o` keeps its value.
- R7: The distance counter saturates and never wraps. If no falling edge of `hsync_i` arrives, one strobe with `field_o`=1 is issued once the counter reaches its maximum of 2^CNT_W-1.
- R8: `field_o` changes only in a cycle where `upd_o` is 1. Between events it holds its value.
- R9: A threshold write (`thr_we_i`, `thr_wdata_i`) takes effect at the next vertical sync start. A write during a measurement does not affect that measurement. A write in the same cycle as a vertical sync start is not used by the measurement that start begins.
- R10: Every decision produces exactly one `upd_o` pulse lasting one cycle.
- R11: A falling edge of `hsync_i` that is detected in the same cycle as a vertical sync start does not end the measurement that start begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_i | input | 1 | Horizontal sync; its falling edge ends a measurement |
| vsync_i | input | 1 | Vertical sync; its active-going edge starts an event |
| fsync_i | input | 1 | External field indication, used when `use_ext_i`=1 |
| use_ext_i | input | 1 | 0 selects the derived decision, 1 selects the external pin |
| slave_i | input | 1 | 1 when the video port is a timing slave; 0 freezes the outputs |
| thr_we_i | input | 1 | Threshold write enable |
| thr_wdata_i | input | 12 | Threshold write value |
| field_o | output | 1 | 0 = first field, 1 = second field |
| upd_o | output | 1 | One-cycle strobe for each update of `field_o` |

## Verification
A vertical sync start can coincide with two other events: a threshold write and a falling edge of horizontal sync. The bench provokes both collisions. In the first, it drives the write in the very cycle the start is detected, then checks that the measurement still uses the old threshold and that the following event uses the new one. In the second, it drops `hsync_i` on the same clock as it raises `vsync_i`. The bench then checks that exactly one strobe appears, and that it comes from the later falling edge, which is judged as second field.

// File: rtl/fpd_pkg.sv
package fpd_pkg;

   typedef enum logic {
      FIELD_FIRST  = 1'b0,
      FIELD_SECOND = 1'b1
   } field_e;

endpackage

// File: rtl/fpd_sync_stage.sv
module fpd_sync_stage #(
   parameter bit ACT_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic edge_o
);

   logic norm;
   logic q1;
   logic q2;

   generate
      if (ACT_HIGH) begin : g_high
         assign norm = d_i;
      end else begin : g_low
         assign norm = ~d_i;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q1 <= 1'b0;
         q2 <= 1'b0;
      end else begin
         q1 <= norm;
         q2 <= q1;
      end
   end

   assign edge_o = q1 & ~q2;

endmodule

// File: rtl/fpd_gap_counter.sv
module fpd_gap_counter #(
   parameter int CNT_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             abort_i,
   input  logic             edge_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             busy_o,
   output logic             done_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   logic at_max;

   assign at_max = (cnt_o == CNT_MAX);
   assign done_o = busy_o & ~start_i & ~abort_i & (edge_i | at_max);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_o  <= '0;
         busy_o <= 1'b0;
      end else if (start_i) begin
         cnt_o  <= CNT_ONE;
         busy_o <= 1'b1;
      end else if (abort_i || done_o) begin
         busy_o <= 1'b0;
      end else if (busy_o) begin
         cnt_o <= cnt_o + CNT_ONE;
      end
   end

endmodule

// File: rtl/fpd_decide.sv
module fpd_decide
   import fpd_pkg::*;
#(
   parameter int CNT_W = 13,
   parameter int THR_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             slave_i,
   input  logic             ext_upd_i,
   input  logic             ext_val_i,
   input  logic             done_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [THR_W-1:0] thr_i,
   output logic             field_o,
   output logic             upd_o
);

   localparam int PAD_W = CNT_W - THR_W;

   field_e field_q;
   field_e verdict;

   assign verdict = (cnt_i > {{PAD_W{1'b0}}, thr_i}) ? FIELD_SECOND : FIELD_FIRST;
   assign field_o = field_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         field_q <= FIELD_FIRST;
         upd_o   <= 1'b0;
      end else begin
         upd_o <= 1'b0;
         if (slave_i) begin
            if (ext_upd_i) begin
               field_q <= field_e'(ext_val_i);
               upd_o   <= 1'b1;
            end else if (done_i) begin
               field_q <= verdict;
               upd_o   <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/field_parity_detect.sv
module field_parity_detect #(
   parameter int         THR_W       = 12,
   parameter int         CNT_W       = 13,
   parameter int         THR_RESET   = 128,
   parameter bit         VS_ACT_HIGH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hsync_i,
   input  logic             vsync_i,
   input  logic             fsync_i,
   input  logic             use_ext_i,
   input  logic             slave_i,
   input  logic             thr_we_i,
   input  logic [THR_W-1:0] thr_wdata_i,
   output logic             field_o,
   output logic             upd_o
);

   localparam logic [THR_W-1:0] THR_INIT = THR_W'(THR_RESET);

   generate
      if (CNT_W <= THR_W) begin : g_bad_cnt
         $error("CNT_W must exceed THR_W so saturation always reads as second field");
      end
      if (THR_RESET >= (1 << THR_W)) begin : g_bad_thr
         $error("THR_RESET does not fit in THR_W bits");
      end
   endgenerate

   logic             vs_st;
   logic             hs_fall;
   logic             fs_q;
   logic [THR_W-1:0] thr_reg;
   logic [THR_W-1:0] thr_lat;
   logic [CNT_W-1:0] cnt;
   logic             busy;
   logic             done;

   fpd_sync_stage #(.ACT_HIGH(VS_ACT_HIGH)) u_vs (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (vsync_i),
      .edge_o (vs_st)
   );

   fpd_sync_stage #(.ACT_HIGH(1'b0)) u_hs (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (hsync_i),
      .edge_o (hs_fall)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fs_q    <= 1'b0;
         thr_reg <= THR_INIT;
         thr_lat <= THR_INIT;
      end else begin
         fs_q <= fsync_i;
         if (vs_st) thr_lat <= thr_reg;
         if (thr_we_i) thr_reg <= thr_wdata_i;
      end
   end

   fpd_gap_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (vs_st & ~use_ext_i),
      .abort_i (vs_st & use_ext_i),
      .edge_i  (hs_fall),
      .cnt_o   (cnt),
      .busy_o  (busy),
      .done_o  (done)
   );

   fpd_decide #(.CNT_W(CNT_W), .THR_W(THR_W)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .slave_i   (slave_i),
      .ext_upd_i (vs_st & use_ext_i),
      .ext_val_i (fs_q),
      .done_i    (done),
      .cnt_i     (cnt),
      .thr_i     (thr_lat),
      .field_o   (field_o),
      .upd_o     (upd_o)
   );

endmodule

// File: rtl/fpd_checker.sv
module fpd_checker #(
   parameter int THR_W = 12,
   parameter int CNT_W = 13
) (
   input logic             clk,
   input logic             rst_n,
   input logic             slave_i,
   input logic             use_ext_i,
   input logic             vs_st,
   input logic             hs_fall,
   input logic             fs_q,
   input logic             busy,
   input logic [CNT_W-1:0] cnt,
   input logic [THR_W-1:0] thr_lat,
   input logic             field_o,
   input logic             upd_o
);

   localparam logic [CNT_W-1:0] CMAX = '1;
   logic le_thr;
   assign le_thr = (cnt <= {{(CNT_W-THR_W){1'b0}}, thr_lat});

   a_r2_first_le: assert property (@(posedge clk) disable iff (!rst_n)
      busy && hs_fall && !vs_st && slave_i && le_thr |=> upd_o && !field_o);

   a_r3_second_gt: assert property (@(posedge clk) disable iff (!rst_n)
      busy && hs_fall && !vs_st && slave_i && !le_thr |=> upd_o && field_o);

   a_r5_ext_copy: assert property (@(posedge clk) disable iff (!rst_n)
      vs_st && use_ext_i && slave_i |=> upd_o && (field_o == $past(fs_q)));

   a_r6_master_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !slave_i |=> !upd_o && $stable(field_o));

   a_r7_sat_second: assert property (@(posedge clk) disable iff (!rst_n)
      busy && (cnt == CMAX) && !vs_st && slave_i |=> upd_o && field_o);

   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_o |-> $stable(field_o));

   a_r9_thr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !vs_st |=> $stable(thr_lat));

   a_r11_start_wins: assert property (@(posedge clk) disable iff (!rst_n)
      vs_st && !use_ext_i |=> busy && !upd_o);

endmodule

bind field_parity_detect fpd_checker #(.THR_W(THR_W), .CNT_W(CNT_W)) u_fpd_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .slave_i   (slave_i),
   .use_ext_i (use_ext_i),
   .vs_st     (vs_st),
   .hs_fall   (hs_fall),
   .fs_q      (fs_q),
   .busy      (busy),
   .cnt       (cnt),
   .thr_lat   (thr_lat),
   .field_o   (field_o),
   .upd_o     (upd_o)
);

// File: tb/test_field_parity_detect.sv
`timescale 1ns/1ps
module test_field_parity_detect;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hsync_i = 1'b1;
   logic        vsync_i = 1'b0;
   logic        fsync_i = 1'b0;
   logic        use_ext_i = 1'b0;
   logic        slave_i = 1'b1;
   logic        thr_we_i = 1'b0;
   logic [11:0] thr_wdata_i = '0;
   logic        field_o;
   logic        upd_o;

   int checks = 0;
   int errors = 0;
   int seen = 0;
   logic last_field = 1'b0;

   always #5 clk = ~clk;

   field_parity_detect i_field_parity_detect (
      .clk         (clk),
      .rst_n       (rst_n),
      .hsync_i     (hsync_i),
      .vsync_i     (vsync_i),
      .fsync_i     (fsync_i),
      .use_ext_i   (use_ext_i),
      .slave_i     (slave_i),
      .thr_we_i    (thr_we_i),
      .thr_wdata_i (thr_wdata_i),
      .field_o     (field_o),
      .upd_o       (upd_o)
   );

   task automatic check(input logic ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step(input int k);
      for (int i = 0; i < k; i++) begin
         @(negedge clk);
         if (upd_o) begin
            seen++;
            last_field = field_o;
         end
      end
   endtask

   task automatic idle_out();
      hsync_i = 1'b1;
      vsync_i = 1'b0;
      step(4);
   endtask

   task automatic run_derived(input int n, input logic exp, input string tag);
      seen = 0;
      vsync_i = 1'b1;
      step(n);
      hsync_i = 1'b0;
      step(8);
      check(seen == 1, {tag, " R10 strobes"}, seen, 1);
      check(field_o == exp, {tag, " field"}, field_o, exp);
      idle_out();
   endtask

   task automatic t_reset();
      step(2);
      check(field_o == 1'b0, "R1 field after reset", field_o, 0);
      check(upd_o == 1'b0, "R1 strobe after reset", upd_o, 0);
   endtask

   task automatic t_hold();
      logic f0;
      f0 = field_o;
      seen = 0;
      step(50);
      check(seen == 0, "R8 no strobe while idle", seen, 0);
      check(field_o == f0, "R8 field held", field_o, f0);
   endtask

   task automatic t_master();
      logic f0;
      f0 = field_o;
      slave_i = 1'b0;
      seen = 0;
      vsync_i = 1'b1;
      step(5);
      hsync_i = 1'b0;
      step(10);
      check(seen == 0, "R6 no strobe in master", seen, 0);
      check(field_o == f0, "R6 field frozen in master", field_o, f0);
      idle_out();
      slave_i = 1'b1;
      step(2);
   endtask

   task automatic t_coincide();
      seen = 0;
      vsync_i = 1'b1;
      hsync_i = 1'b0;
      step(2);
      hsync_i = 1'b1;
      step(198);
      check(seen == 0, "R11 no early strobe", seen, 0);
      hsync_i = 1'b0;
      step(8);
      check(seen == 1, "R11 one strobe", seen, 1);
      check(last_field == 1'b1, "R11 later edge decides", last_field, 1);
      idle_out();
   endtask

   task automatic t_thr_mid();
      seen = 0;
      vsync_i = 1'b1;
      step(5);
      thr_we_i = 1'b1;
      thr_wdata_i = 12'd20;
      step(1);
      thr_we_i = 1'b0;
      step(54);
      hsync_i = 1'b0;
      step(8);
      check(seen == 1 && field_o == 1'b0, "R9 mid write ignored", field_o, 0);
      idle_out();
      run_derived(60, 1'b1, "R9 new threshold 20 used");
   endtask

   task automatic t_thr_same_cycle();
      seen = 0;
      vsync_i = 1'b1;
      step(1);
      thr_we_i = 1'b1;
      thr_wdata_i = 12'd100;
      step(1);
      thr_we_i = 1'b0;
      step(58);
      hsync_i = 1'b0;
      step(8);
      check(seen == 1 && field_o == 1'b1, "R9 same-cycle write uses old 20", field_o, 1);
      idle_out();
      run_derived(60, 1'b0, "R9 threshold 100 next event");
   endtask

   task automatic t_ext(input logic v);
      use_ext_i = 1'b1;
      fsync_i = v;
      seen = 0;
      step(1);
      vsync_i = 1'b1;
      step(3);
      hsync_i = 1'b0;
      step(8);
      check(seen == 1, "R5 one strobe in external mode", seen, 1);
      check(field_o == v, "R5 field copies fsync", field_o, v);
      idle_out();
      use_ext_i = 1'b0;
   endtask

   task automatic t_sat();
      seen = 0;
      vsync_i = 1'b1;
      step(8100);
      check(seen == 0, "R7 no strobe before saturation", seen, 0);
      step(200);
      check(seen == 1, "R7 one strobe at saturation", seen, 1);
      check(field_o == 1'b1, "R7 saturation gives second", field_o, 1);
      idle_out();
   endtask

   initial begin
      #1500000;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      run_derived(129, 1'b1, "R3 R4 above reset threshold");
      run_derived(128, 1'b0, "R2 R4 equal to reset threshold");
      run_derived(1, 1'b0, "R2 shortest gap");
      run_derived(300, 1'b1, "R3 long gap");
      t_hold();
      t_master();
      run_derived(10, 1'b0, "R2 back in slave");
      t_coincide();
      t_thr_mid();
      t_thr_same_cycle();
      t_ext(1'b1);
      t_ext(1'b0);
      t_sat();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule